// File: doc/BRIEF.md
# Message Queue Engine with Waiting Receivers

This block is the message-queue part of a hardware real-time kernel accelerator. It holds fixed-width message handles in a bounded buffer. It also keeps a list of tasks that are blocked waiting to receive. A requester presents one command at a time: a normal send, an urgent send, a broadcast or a receive. Each command carries a task identifier, a priority and, for the three send kinds, a message handle.

A buffered message and a waiting receiver never exist together. A send that finds receivers waiting skips the buffer and gives the message straight to the first waiter. A broadcast gives one message to every waiter, one per cycle, and raises `busy` until the list is empty. Two things are fixed per instance by parameters: how waiters are ordered (arrival order or priority), and what a send to a full buffer does (error or blocked status). The result beat tells the kernel software which task to wake, which message a receiver got, or why a call could not finish.

Top module: `msgq_engine`

## Requirements
- R1: A normal send (cmd_op 0) with no waiters stores the message at the tail and returns status 0 (OK). Receives (cmd_op 3) return buffered messages oldest first, with status 0.
- R2: An urgent send (cmd_op 1) with no waiters stores the message at the head. Several urgent sends therefore come out newest first, and all of them come out ahead of normally sent messages.
- R3: A receive on an empty buffer puts the caller on the waiter list and returns status 2 (BLOCKED), with res_tid set to the caller. If the list already holds WDEPTH tasks, the receive returns status 4 (WAITFULL) and the list is unchanged.
- R4: With PRIO_ORDER=0, waiters are served in the order they arrived.
- R5: With PRIO_ORDER=1, a waiter with a larger priority value is served first. Waiters of equal priority are served in arrival order.
- R6: A send of either kind that finds waiters does not touch the buffer. It returns status 1 (HANDOFF) with res_tid set to the head waiter. In the same cycle, the wake port shows that task and the message.
- R7: A send to a full buffer with no waiters leaves the buffer unchanged. It returns status 3 (FULL) when BLOCK_ON_FULL=0 and status 2 (BLOCKED) when BLOCK_ON_FULL=1.
- R8: A broadcast (cmd_op 2) with N waiters raises busy for N cycles. It wakes one waiter per cycle in service order, each with the broadcast message. Its single result beat has status 0 and res_count N, and it comes in the same cycle as the last wake.
- R9: A broadcast with no waiters returns status 0 with res_count 0 on the next cycle. It produces no wake beat and leaves buffered messages unchanged.
- R10: Every command accepted while busy is low produces exactly one result beat: one cycle after acceptance, or N+1 cycles for a broadcast with N waiters. No beat appears otherwise.
- R11: After reset, res_valid, wake_valid and busy are low, and the buffer and waiter list are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present; accepted on a rising edge when busy is low |
| cmd_op | input | 2 | 0 send, 1 urgent send, 2 broadcast, 3 receive |
| cmd_tid | input | TID_W | Calling task identifier |
| cmd_prio | input | PRIO_W | Calling task priority (larger is more urgent) |
| cmd_msg | input | MSG_W | Message handle for the send kinds |
| busy | output | 1 | Broadcast drain in progress; commands are not taken |
| res_valid | output | 1 | One-cycle result strobe |
| res_status | output | 3 | 0 OK, 1 HANDOFF, 2 BLOCKED, 3 FULL, 4 WAITFULL |
| res_msg | output | MSG_W | Message received, handed off or broadcast |
| res_tid | output | TID_W | Woken task for HANDOFF, otherwise the caller |
| res_count | output | clog2(WDEPTH+1) | Number of tasks woken by a broadcast |
| wake_valid | output | 1 | A waiting task is made ready this cycle |
| wake_tid | output | TID_W | Task being woken |
| wake_msg | output | MSG_W | Message delivered to that task |

## Verification
A corrupted buffer shift or a wrong insertion slot shows up as a message returned out of order, on the first receive that reaches the damaged entry. A bad waiter insertion shows up as the wrong res_tid or wake_tid on the next hand-off or broadcast. A count that drifts shows up within one command, as a wrong FULL, BLOCKED or WAITFULL status at the boundaries, or as a broadcast whose busy length and res_count differ from the number of receivers queued before it.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
  localparam logic [1:0] OP_SEND   = 2'd0;
  localparam logic [1:0] OP_URGENT = 2'd1;
  localparam logic [1:0] OP_BCAST  = 2'd2;
  localparam logic [1:0] OP_RECV   = 2'd3;

  localparam logic [2:0] ST_OK       = 3'd0;
  localparam logic [2:0] ST_HANDOFF  = 3'd1;
  localparam logic [2:0] ST_BLOCKED  = 3'd2;
  localparam logic [2:0] ST_FULL     = 3'd3;
  localparam logic [2:0] ST_WAITFULL = 3'd4;

  // A new waiter goes ahead of a queued one only when strictly more urgent,
  // so equal priorities keep arrival order.
  function automatic logic jumps_ahead(input int unsigned newp, input int unsigned oldp);
    return newp > oldp;
  endfunction

  function automatic logic is_send(input logic [1:0] op);
    return (op == OP_SEND) || (op == OP_URGENT);
  endfunction
endpackage

// File: rtl/msgq_buffer.sv
module msgq_buffer #(
  parameter int DEPTH = 8,
  parameter int W     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_tail,
  input  logic                         push_head,
  input  logic                         pop,
  input  logic [W-1:0]                 din,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];

  assign head = mem[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) mem[i] <= mem[i+1];
      count <= count - 1'b1;
    end else if (push_head) begin
      for (int i = 1; i < DEPTH; i++) mem[i] <= mem[i-1];
      mem[0] <= din;
      count  <= count + 1'b1;
    end else if (push_tail) begin
      mem[count[AW-1:0]] <= din;
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/msgq_waitlist.sv
module msgq_waitlist #(
  parameter int WDEPTH     = 8,
  parameter int TID_W      = 4,
  parameter int PRIO_W     = 4,
  parameter bit PRIO_ORDER = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ins,
  input  logic [TID_W-1:0]              ins_tid,
  input  logic [PRIO_W-1:0]             ins_prio,
  input  logic                          pop,
  output logic [TID_W-1:0]              head_tid,
  output logic [$clog2(WDEPTH+1)-1:0]   count
);
  import msgq_pkg::*;
  localparam int CW = $clog2(WDEPTH+1);

  logic [TID_W-1:0]  tid_q  [WDEPTH];
  logic [PRIO_W-1:0] prio_q [WDEPTH];
  logic [CW-1:0]     slot;

  generate
    if (PRIO_ORDER) begin : g_prio
      always_comb begin
        slot = count;
        for (int i = WDEPTH - 1; i >= 0; i--)
          if (CW'(i) < count && jumps_ahead(int'(ins_prio), int'(prio_q[i])))
            slot = CW'(i);
      end
    end else begin : g_fifo
      assign slot = count;
    end
  endgenerate

  assign head_tid = tid_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < WDEPTH; i++) begin
        tid_q[i]  <= '0;
        prio_q[i] <= '0;
      end
    end else if (pop) begin
      for (int i = 0; i < WDEPTH - 1; i++) begin
        tid_q[i]  <= tid_q[i+1];
        prio_q[i] <= prio_q[i+1];
      end
      count <= count - 1'b1;
    end else if (ins) begin
      if (slot == '0) begin
        tid_q[0]  <= ins_tid;
        prio_q[0] <= ins_prio;
      end
      for (int i = 1; i < WDEPTH; i++) begin
        if (CW'(i) == slot) begin
          tid_q[i]  <= ins_tid;
          prio_q[i] <= ins_prio;
        end else if (CW'(i) > slot) begin
          tid_q[i]  <= tid_q[i-1];
          prio_q[i] <= prio_q[i-1];
        end
      end
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/msgq_engine.sv
module msgq_engine #(
  parameter int DEPTH         = 8,
  parameter int MSG_W         = 16,
  parameter int WDEPTH        = 8,
  parameter int TID_W         = 4,
  parameter int PRIO_W        = 4,
  parameter bit PRIO_ORDER    = 1'b0,
  parameter bit BLOCK_ON_FULL = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  input  logic [1:0]                   cmd_op,
  input  logic [TID_W-1:0]             cmd_tid,
  input  logic [PRIO_W-1:0]            cmd_prio,
  input  logic [MSG_W-1:0]             cmd_msg,
  output logic                         busy,
  output logic                         res_valid,
  output logic [2:0]                   res_status,
  output logic [MSG_W-1:0]             res_msg,
  output logic [TID_W-1:0]             res_tid,
  output logic [$clog2(WDEPTH+1)-1:0]  res_count,
  output logic                         wake_valid,
  output logic [TID_W-1:0]             wake_tid,
  output logic [MSG_W-1:0]             wake_msg
);
  import msgq_pkg::*;
  localparam int MCW = $clog2(DEPTH+1);
  localparam int WCW = $clog2(WDEPTH+1);

  logic [MCW-1:0]   m_count;
  logic [MSG_W-1:0] m_head;
  logic [WCW-1:0]   w_count;
  logic [TID_W-1:0] w_head;
  logic             in_bcast;
  logic [MSG_W-1:0] bc_msg;
  logic [WCW-1:0]   bc_n;

  // Named internal events, also observed by the checker.
  logic accept, m_full, m_empty, w_full, w_empty;
  logic do_handoff, do_tail, do_head, do_take, do_wait, w_pop;

  assign busy    = in_bcast;
  assign accept  = cmd_valid && !in_bcast;
  assign m_full  = (m_count == MCW'(DEPTH));
  assign m_empty = (m_count == '0);
  assign w_full  = (w_count == WCW'(WDEPTH));
  assign w_empty = (w_count == '0);

  assign do_handoff = accept && is_send(cmd_op) && !w_empty;
  assign do_tail    = accept && (cmd_op == OP_SEND)   && w_empty && !m_full;
  assign do_head    = accept && (cmd_op == OP_URGENT) && w_empty && !m_full;
  assign do_take    = accept && (cmd_op == OP_RECV)   && !m_empty;
  assign do_wait    = accept && (cmd_op == OP_RECV)   && m_empty && !w_full;
  assign w_pop      = do_handoff || in_bcast;

  msgq_buffer #(.DEPTH(DEPTH), .W(MSG_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .push_tail(do_tail), .push_head(do_head), .pop(do_take),
    .din(cmd_msg), .head(m_head), .count(m_count)
  );

  msgq_waitlist #(.WDEPTH(WDEPTH), .TID_W(TID_W), .PRIO_W(PRIO_W),
                  .PRIO_ORDER(PRIO_ORDER)) u_wait (
    .clk(clk), .rst_n(rst_n),
    .ins(do_wait), .ins_tid(cmd_tid), .ins_prio(cmd_prio),
    .pop(w_pop), .head_tid(w_head), .count(w_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_bcast   <= 1'b0;
      bc_msg     <= '0;
      bc_n       <= '0;
      res_valid  <= 1'b0;
      res_status <= ST_OK;
      res_msg    <= '0;
      res_tid    <= '0;
      res_count  <= '0;
      wake_valid <= 1'b0;
      wake_tid   <= '0;
      wake_msg   <= '0;
    end else begin
      res_valid  <= 1'b0;
      wake_valid <= 1'b0;
      if (accept) begin
        res_valid <= 1'b1;
        res_tid   <= cmd_tid;
        res_msg   <= cmd_msg;
        res_count <= '0;
        unique case (cmd_op)
          OP_SEND, OP_URGENT: begin
            if (!w_empty) begin
              res_status <= ST_HANDOFF;
              res_tid    <= w_head;
              wake_valid <= 1'b1;
              wake_tid   <= w_head;
              wake_msg   <= cmd_msg;
            end else if (!m_full) begin
              res_status <= ST_OK;
            end else begin
              res_status <= BLOCK_ON_FULL ? ST_BLOCKED : ST_FULL;
            end
          end
          OP_BCAST: begin
            res_status <= ST_OK;
            if (!w_empty) begin
              res_valid <= 1'b0;
              in_bcast  <= 1'b1;
              bc_msg    <= cmd_msg;
              bc_n      <= '0;
            end
          end
          default: begin
            if (!m_empty) begin
              res_status <= ST_OK;
              res_msg    <= m_head;
            end else if (!w_full) begin
              res_status <= ST_BLOCKED;
            end else begin
              res_status <= ST_WAITFULL;
            end
          end
        endcase
      end
      if (in_bcast) begin
        wake_valid <= 1'b1;
        wake_tid   <= w_head;
        wake_msg   <= bc_msg;
        bc_n       <= bc_n + 1'b1;
        if (w_count == WCW'(1)) begin
          in_bcast   <= 1'b0;
          res_valid  <= 1'b1;
          res_status <= ST_OK;
          res_msg    <= bc_msg;
          res_count  <= bc_n + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/msgq_checker.sv
module msgq_checker #(
  parameter int DEPTH  = 8,
  parameter int WDEPTH = 8,
  parameter int TID_W  = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         accept,
  input logic [1:0]                   cmd_op,
  input logic                         busy,
  input logic                         res_valid,
  input logic [2:0]                   res_status,
  input logic [TID_W-1:0]             res_tid,
  input logic                         wake_valid,
  input logic [TID_W-1:0]             wake_tid,
  input logic [$clog2(DEPTH+1)-1:0]   m_count,
  input logic [$clog2(WDEPTH+1)-1:0]  w_count,
  input logic                         m_full
);
  import msgq_pkg::*;

  assert_beat_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op != OP_BCAST) |=> res_valid);

  assert_no_spurious_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !busy) |=> !res_valid);

  assert_handoff_wakes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status == ST_HANDOFF) |-> (wake_valid && wake_tid == res_tid));

  assert_msgs_xor_waiters_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_count != '0) |-> (w_count == '0));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_send(cmd_op) && m_full && w_count == '0) |=> $stable(m_count));

  assert_drain_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (wake_valid && w_count == $past(w_count) - 1'b1));
endmodule

bind msgq_engine msgq_checker #(.DEPTH(DEPTH), .WDEPTH(WDEPTH), .TID_W(TID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .cmd_op(cmd_op), .busy(busy),
  .res_valid(res_valid), .res_status(res_status), .res_tid(res_tid),
  .wake_valid(wake_valid), .wake_tid(wake_tid),
  .m_count(m_count), .w_count(w_count), .m_full(m_full)
);

// File: tb/sim_msgq_engine.sv
`timescale 1ns/1ps
module sim_msgq_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cv   [2];
  logic [1:0]  cop  [2];
  logic [3:0]  ctid [2];
  logic [3:0]  cpri [2];
  logic [15:0] cmsg [2];
  logic        bsy  [2];
  logic        rv   [2];
  logic [2:0]  rst_s[2];
  logic [15:0] rmsg [2];
  logic [3:0]  rtid [2];
  logic [3:0]  rcnt [2];
  logic        wv   [2];
  logic [3:0]  wtid [2];
  logic [15:0] wmsg [2];

  // u0: priority-ordered waiters, blocking on full. u1: FIFO waiters, error on full.
  msgq_engine #(.PRIO_ORDER(1'b1), .BLOCK_ON_FULL(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cv[0]), .cmd_op(cop[0]), .cmd_tid(ctid[0]),
    .cmd_prio(cpri[0]), .cmd_msg(cmsg[0]), .busy(bsy[0]), .res_valid(rv[0]),
    .res_status(rst_s[0]), .res_msg(rmsg[0]), .res_tid(rtid[0]), .res_count(rcnt[0]),
    .wake_valid(wv[0]), .wake_tid(wtid[0]), .wake_msg(wmsg[0]));
  msgq_engine #(.PRIO_ORDER(1'b0), .BLOCK_ON_FULL(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cv[1]), .cmd_op(cop[1]), .cmd_tid(ctid[1]),
    .cmd_prio(cpri[1]), .cmd_msg(cmsg[1]), .busy(bsy[1]), .res_valid(rv[1]),
    .res_status(rst_s[1]), .res_msg(rmsg[1]), .res_tid(rtid[1]), .res_count(rcnt[1]),
    .wake_valid(wv[1]), .wake_tid(wtid[1]), .wake_msg(wmsg[1]));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic        s_valid, s_busy, s_wake;
  logic [2:0]  s_status;
  logic [15:0] s_msg, s_wmsg;
  logic [3:0]  s_tid, s_cnt, s_wtid;
  int          b_wakes, b_busy;
  logic [3:0]  b_tids [16];

  function automatic logic [15:0] msg_of(input int k);
    return 16'h3000 + 16'(k * 97);
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input int q, input int op, input int tid, input int pri, input int msg);
    @(negedge clk);
    cv[q] = 1'b1; cop[q] = op[1:0]; ctid[q] = tid[3:0]; cpri[q] = pri[3:0]; cmsg[q] = msg[15:0];
    @(negedge clk);
    cv[q] = 1'b0;
    s_valid = rv[q]; s_status = rst_s[q]; s_msg = rmsg[q]; s_tid = rtid[q];
    s_cnt = rcnt[q]; s_busy = bsy[q]; s_wake = wv[q]; s_wtid = wtid[q]; s_wmsg = wmsg[q];
    if (op != 2) chk("R10", "result beat one cycle after accept", s_valid, 1);
  endtask

  task automatic bcast(input int q, input int msg);
    issue(q, 2, 0, 0, msg);
    b_wakes = 0; b_busy = 0;
    for (int g = 0; g < 20; g++) begin
      if (bsy[q]) b_busy++;
      if (wv[q]) begin
        b_tids[b_wakes] = wtid[q];
        chk("R8", "broadcast wake message", wmsg[q], msg);
        b_wakes++;
      end
      if (rv[q]) break;
      @(negedge clk);
    end
    s_valid = rv[q]; s_status = rst_s[q]; s_cnt = rcnt[q];
    chk("R10", "broadcast result beat", s_valid, 1);
  endtask

  initial begin
    for (int q = 0; q < 2; q++) begin
      cv[q] = 0; cop[q] = 0; ctid[q] = 0; cpri[q] = 0; cmsg[q] = 0;
    end
    repeat (3) @(negedge clk);
    for (int q = 0; q < 2; q++) begin
      chk("R11", "res_valid in reset", rv[q], 0);
      chk("R11", "wake_valid in reset", wv[q], 0);
      chk("R11", "busy in reset", bsy[q], 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "no beat after reset", rv[0] | rv[1] | wv[0] | wv[1], 0);

    // R1, R7 on u1 (error on full): fill, overflow, drain in order.
    for (int k = 0; k < 8; k++) begin
      issue(1, 0, 1, 0, msg_of(k));
      chk("R1", "send status", s_status, 0);
    end
    issue(1, 0, 1, 0, 16'hDEAD);
    chk("R7", "full send status (error mode)", s_status, 3);
    @(negedge clk);
    chk("R10", "no beat when idle", rv[1], 0);
    for (int k = 0; k < 8; k++) begin
      issue(1, 3, 2, 0, 0);
      chk("R1", "receive status", s_status, 0);
      chk("R1", "receive order", s_msg, msg_of(k));
    end

    // R3, R4, R6 on u1: fill the waiter list, overflow it, hand off in arrival order.
    for (int k = 0; k < 8; k++) begin
      issue(1, 3, k + 1, 7 - k, 0);
      chk("R3", "receive on empty status", s_status, 2);
      chk("R3", "blocked caller id", s_tid, k + 1);
    end
    issue(1, 3, 12, 15, 0);
    chk("R3", "waiter list full status", s_status, 4);
    for (int k = 0; k < 8; k++) begin
      issue(1, (k % 2), 0, 0, msg_of(20 + k));
      chk("R6", "hand-off status", s_status, 1);
      chk("R4", "fifo waiter served", s_tid, k + 1);
      chk("R6", "wake strobe with hand-off", s_wake, 1);
      chk("R6", "wake tid", s_wtid, k + 1);
      chk("R6", "wake message", s_wmsg, msg_of(20 + k));
    end
    issue(1, 3, 3, 0, 0);
    chk("R6", "hand-off left buffer empty", s_status, 2);
    issue(1, 0, 0, 0, 16'h0BAD);
    chk("R6", "clears the waiter", s_status, 1);

    // R2 on u1: urgent sends jump ahead, newest first.
    issue(1, 0, 1, 0, 16'h0001);
    issue(1, 0, 1, 0, 16'h0002);
    issue(1, 1, 1, 0, 16'h0003);
    chk("R2", "urgent send status", s_status, 0);
    issue(1, 1, 1, 0, 16'h0004);
    begin
      logic [15:0] exp_o [4];
      exp_o[0] = 16'h0004; exp_o[1] = 16'h0003; exp_o[2] = 16'h0001; exp_o[3] = 16'h0002;
      for (int k = 0; k < 4; k++) begin
        issue(1, 3, 2, 0, 0);
        chk("R2", "urgent ordering", s_msg, exp_o[k]);
      end
    end

    // R5, R8 on u0: priority waiters drained by broadcast.
    begin
      int ap [8];
      logic [3:0] exp_t [8];
      int n;
      ap[0] = 3; ap[1] = 7; ap[2] = 3; ap[3] = 9; ap[4] = 7; ap[5] = 0; ap[6] = 9; ap[7] = 3;
      for (int k = 0; k < 8; k++) begin
        issue(0, 3, k + 1, ap[k], 0);
        chk("R3", "priority waiter blocked", s_status, 2);
      end
      n = 0;
      for (int p = 15; p >= 0; p--)
        for (int k = 0; k < 8; k++)
          if (ap[k] == p) begin exp_t[n] = 4'(k + 1); n++; end
      bcast(0, 16'hBC01);
      chk("R8", "broadcast wake count", b_wakes, 8);
      chk("R8", "busy cycles", b_busy, 8);
      chk("R8", "broadcast status", s_status, 0);
      chk("R8", "broadcast res_count", s_cnt, 8);
      for (int k = 0; k < 8; k++)
        chk("R5", "priority service order", b_tids[k], exp_t[k]);
    end

    // R9 on u0: broadcast with nobody waiting.
    issue(0, 0, 1, 0, 16'h7777);
    bcast(0, 16'hBC02);
    chk("R9", "empty broadcast count", s_cnt, 0);
    chk("R9", "empty broadcast wakes", b_wakes, 0);
    chk("R9", "empty broadcast status", s_status, 0);
    issue(0, 3, 1, 0, 0);
    chk("R9", "buffer kept after broadcast", s_msg, 16'h7777);

    // R7 on u0 (blocking mode): full send blocked, contents intact.
    for (int k = 0; k < 8; k++) issue(0, 0, 1, 0, msg_of(40 + k));
    issue(0, 1, 1, 0, 16'hEEEE);
    chk("R7", "full send status (block mode)", s_status, 2);
    for (int k = 0; k < 8; k++) begin
      issue(0, 3, 1, 0, 0);
      chk("R7", "contents after blocked send", s_msg, msg_of(40 + k));
    end
    issue(0, 3, 1, 0, 0);
    chk("R7", "buffer empty after drain", s_status, 2);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule